// File: doc/BRIEF.md
# Float / Unsigned Integer Converter

This block converts in both directions between 32-bit single-precision floating-point values and 32-bit unsigned integers. A direction bit that travels with each operand selects the conversion. Float-to-unsigned always truncates toward zero. It gives fixed saturated results for infinities, NaNs, negative values and values that are too large, and it reports an invalid-operation flag or an unimplemented-operand flag for them. Unsigned-to-float normalises the integer to a 24-bit significand and rounds away the low bits under a 2-bit rounding mode. Both directions report a zero flag and a sign flag.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream. The conversion logic is combinational and is followed by a single output register. A word accepted at a clock edge therefore appears on the output from that same edge, one cycle after the input strobe.

Back-pressure rules:
- An input word is taken on a rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the result and all flags hold their values, and no new word is taken.

Top module: `fp_uint_convert`

## Requirements
- R1: While reset is asserted and after reset, `out_valid` is 0 and `in_ready` is 1 until a word is taken.
- R2: With `in_dir` = 0 (float to unsigned), +0 (0x00000000) and −0 (0x80000000) give 0 with no flag. A positive normal value below 2^32 gives its integer part, truncated toward zero, whatever `in_rmode` holds.
- R3: With `in_dir` = 0, +infinity (0x7F800000) gives 0xFFFFFFFF and −infinity (0xFF800000) gives 0, both with `out_invalid` set. A positive normal value whose unbiased exponent is 32 or more gives 0xFFFFFFFF with `out_invalid` set. A negative normal value gives 0 with no flag.
- R4: With `in_dir` = 0, a NaN (exponent field all ones, fraction non-zero, quiet or signalling) gives 0xFFFFFFFF with bit 31 clear and 0 with bit 31 set, with `out_invalid` set in both cases.
- R5: With `in_dir` = 0, a denormal (exponent field 0, fraction non-zero) of either sign gives 0 with `out_unimpl` set and `out_invalid` clear. The two exception flags are never set together.
- R6: With `in_dir` = 1 (unsigned to float), input 0 gives +0.0 (0x00000000). Any other input gives sign 0, biased exponent 158 minus the number of leading zeros, and the 23 bits that follow the leading one as the fraction. The result is exact when the input has at most 24 significant bits.
- R7: With `in_dir` = 1, the 8 bits dropped after normalisation are rounded by `in_rmode`. 00 (nearest) adds one when the top dropped bit is set. 10 (toward +infinity) adds one when any dropped bit is set. 01 (toward zero) and 11 (toward −infinity) truncate.
- R8: With `in_dir` = 1, if rounding carries out of the 24-bit significand, the significand becomes 1.0 and the exponent rises by one (0xFFFFFFFF at nearest gives 0x4F800000).
- R9: `out_zero` is set exactly when `out_result` is 0. `out_sign` is always 0 for `in_dir` = 1 and equals bit 31 of the integer result for `in_dir` = 0. Neither exception flag is ever set for `in_dir` = 1.
- R10: A word taken at a rising edge is presented with `out_valid` high after that edge. While `out_ready` is low, the output holds stable and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Converter can take a word |
| in_dir | input | 1 | 0: float to unsigned, 1: unsigned to float |
| in_rmode | input | 2 | Rounding mode for unsigned to float (00 nearest, 01 zero, 10 +inf, 11 −inf) |
| in_operand | input | 32 | Float bit pattern or unsigned integer |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream can take the result |
| out_result | output | 32 | Converted value |
| out_invalid | output | 1 | Invalid-operation flag |
| out_unimpl | output | 1 | Unimplemented-operand (denormal) flag |
| out_zero | output | 1 | Result is zero |
| out_sign | output | 1 | Result sign flag |

## Verification
All state sits in the one output register, so a fault in it appears on the very next output word. A stuck or lost valid bit shows as a missing result or a duplicated one. A result that changes while the output is stalled shows up while `out_ready` is held low. A wrong stage in the leading-zero shifter moves the exponent by a power of two and mangles the fraction on the first unsigned input with that many leading zeros. Rounding and carry faults appear only when the dropped bits are patterned, so the directed cases place a set bit at the top of the dropped byte, a set bit below the top, and an all-ones input.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int FP_W   = 1 + EXP_W + FRAC_W;
  localparam int INT_W  = 32;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_POS     = 2'b10,
    RM_NEG     = 2'b11
  } rmode_e;

  typedef enum logic [2:0] {
    CL_ZERO,
    CL_NORM,
    CL_DENORM,
    CL_INF,
    CL_QNAN,
    CL_SNAN
  } fclass_e;
endpackage

// File: rtl/fcvt_classify.sv
module fcvt_classify
  import fcvt_pkg::*;
(
  input  logic [FP_W-1:0]   op_i,
  output logic              sign_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [FRAC_W-1:0] frac_o,
  output fclass_e           cls_o
);
  localparam logic [EXP_W-1:0] EXP_ONES = '1;

  always_comb begin
    sign_o = op_i[FP_W-1];
    exp_o  = op_i[FP_W-2 -: EXP_W];
    frac_o = op_i[FRAC_W-1:0];
    if (exp_o == '0)
      cls_o = (frac_o == '0) ? CL_ZERO : CL_DENORM;
    else if (exp_o == EXP_ONES) begin
      if (frac_o == '0)
        cls_o = CL_INF;
      else
        cls_o = frac_o[FRAC_W-1] ? CL_QNAN : CL_SNAN;
    end else
      cls_o = CL_NORM;
  end
endmodule

// File: rtl/fcvt_f2u.sv
module fcvt_f2u
  import fcvt_pkg::*;
(
  input  logic              sign_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  fclass_e           cls_i,
  output logic [INT_W-1:0]  res_o,
  output logic              invalid_o,
  output logic              unimpl_o
);
  localparam int SHW = $clog2(INT_W + FRAC_W + 1);
  localparam logic signed [EXP_W+1:0] LIMIT = $signed((EXP_W+2)'(INT_W));
  localparam logic signed [EXP_W+1:0] BIASV = $signed((EXP_W+2)'(BIAS));

  logic signed [EXP_W+1:0] unb;
  logic [SHW-1:0]          shamt;

  always_comb begin
    unb       = $signed({2'b00, exp_i}) - BIASV;
    shamt     = unb[SHW-1:0];
    res_o     = '0;
    invalid_o = 1'b0;
    unimpl_o  = 1'b0;
    case (cls_i)
      CL_ZERO: res_o = '0;
      CL_DENORM: unimpl_o = 1'b1;
      CL_INF, CL_QNAN, CL_SNAN: begin
        invalid_o = 1'b1;
        res_o     = sign_i ? '0 : '1;
      end
      default: begin
        if (sign_i)
          res_o = '0;
        else if (unb[EXP_W+1])
          res_o = '0;
        else if (unb >= LIMIT) begin
          invalid_o = 1'b1;
          res_o     = '1;
        end else
          res_o = INT_W'(({{INT_W{1'b0}}, 1'b1, frac_i} << shamt) >> FRAC_W);
      end
    endcase
  end
endmodule

// File: rtl/fcvt_norm.sv
module fcvt_norm #(
  parameter int W = 32
) (
  input  logic [W-1:0]         val_i,
  output logic [W-1:0]         norm_o,
  output logic [$clog2(W)-1:0] lz_o
);
  localparam int STAGES = $clog2(W);

  logic [W-1:0]      stg [STAGES+1];
  logic [STAGES-1:0] cnt;

  assign stg[0] = val_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int SH = 1 << (STAGES - 1 - s);
    assign cnt[STAGES-1-s] = (stg[s][W-1 -: SH] == '0);
    assign stg[s+1] = cnt[STAGES-1-s] ? (stg[s] << SH) : stg[s];
  end

  assign norm_o = stg[STAGES];
  assign lz_o   = cnt;
endmodule

// File: rtl/fcvt_u2f.sv
module fcvt_u2f
  import fcvt_pkg::*;
(
  input  logic [INT_W-1:0] val_i,
  input  rmode_e           rmode_i,
  output logic [FP_W-1:0]  res_o
);
  localparam int SIG_W  = FRAC_W + 1;
  localparam int DROP_W = INT_W - SIG_W;
  localparam int LZ_W   = $clog2(INT_W);
  localparam logic [EXP_W-1:0] TOP_EXP = EXP_W'(BIAS + INT_W - 1);

  logic [INT_W-1:0]  norm;
  logic [LZ_W-1:0]   lz;
  logic [SIG_W-1:0]  keep;
  logic [DROP_W-1:0] drop;
  logic              bump;
  logic [SIG_W:0]    sum;
  logic [EXP_W-1:0]  bexp;
  logic [FRAC_W-1:0] man;

  fcvt_norm #(.W(INT_W)) u_norm (
    .val_i  (val_i),
    .norm_o (norm),
    .lz_o   (lz)
  );

  always_comb begin
    keep = norm[INT_W-1 -: SIG_W];
    drop = norm[DROP_W-1:0];
    case (rmode_i)
      RM_NEAREST: bump = drop[DROP_W-1];
      RM_POS:     bump = |drop;
      default:    bump = 1'b0;
    endcase
    sum  = {1'b0, keep} + (SIG_W+1)'(bump);
    bexp = TOP_EXP - EXP_W'(lz);
    if (sum[SIG_W]) begin
      man  = sum[FRAC_W:1];
      bexp = bexp + EXP_W'(1);
    end else
      man = sum[FRAC_W-1:0];
    if (val_i == '0)
      res_o = '0;
    else
      res_o = {1'b0, bexp, man};
  end
endmodule

// File: rtl/fp_uint_convert.sv
module fp_uint_convert
  import fcvt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_dir,
  input  logic [1:0]       in_rmode,
  input  logic [INT_W-1:0] in_operand,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [INT_W-1:0] out_result,
  output logic             out_invalid,
  output logic             out_unimpl,
  output logic             out_zero,
  output logic             out_sign
);
  logic              f_sign;
  logic [EXP_W-1:0]  f_exp;
  logic [FRAC_W-1:0] f_frac;
  fclass_e           f_cls;
  logic [INT_W-1:0]  f2u_res;
  logic              f2u_inv;
  logic              f2u_unimpl;
  logic [FP_W-1:0]   u2f_res;
  logic [INT_W-1:0]  sel_res;
  logic              take;
  logic              dir_q;

  fcvt_classify u_cls (
    .op_i   (in_operand),
    .sign_o (f_sign),
    .exp_o  (f_exp),
    .frac_o (f_frac),
    .cls_o  (f_cls)
  );

  fcvt_f2u u_f2u (
    .sign_i    (f_sign),
    .exp_i     (f_exp),
    .frac_i    (f_frac),
    .cls_i     (f_cls),
    .res_o     (f2u_res),
    .invalid_o (f2u_inv),
    .unimpl_o  (f2u_unimpl)
  );

  fcvt_u2f u_u2f (
    .val_i   (in_operand),
    .rmode_i (rmode_e'(in_rmode)),
    .res_o   (u2f_res)
  );

  assign sel_res  = in_dir ? INT_W'(u2f_res) : f2u_res;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign out_sign = !dir_q && out_result[INT_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      out_unimpl  <= 1'b0;
      out_zero    <= 1'b0;
      dir_q       <= 1'b0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_result  <= sel_res;
      out_invalid <= !in_dir && f2u_inv;
      out_unimpl  <= !in_dir && f2u_unimpl;
      out_zero    <= (sel_res == '0);
      dir_q       <= in_dir;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10: a stalled result holds
  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
    $stable(out_invalid) && $stable(out_unimpl) && $stable(out_zero));

  // R10: an accepted word yields a valid output next
  p_accept_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R5: exception flags exclusive
  p_excl_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_unimpl));

  // R5: unimplemented operand gives zero
  p_unimpl_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unimpl |-> out_result == '0);

  // R9: integer-to-float never raises an exception and is never negative
  p_u2f_noexc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && dir_q |-> !out_invalid && !out_unimpl && !out_result[INT_W-1]);

  // R9: zero flag tracks the result
  p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_zero == (out_result == '0));
endmodule

// File: tb/tb_fp_uint_convert.sv
module tb_fp_uint_convert;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_dir = 1'b0;
  logic [1:0]  in_rmode = 2'b00;
  logic [31:0] in_operand = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_invalid, out_unimpl, out_zero, out_sign;

  int checks = 0;
  int errors = 0;

  fp_uint_convert dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dir(in_dir), .in_rmode(in_rmode), .in_operand(in_operand),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_invalid(out_invalid), .out_unimpl(out_unimpl), .out_zero(out_zero),
    .out_sign(out_sign)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [36:0] act, input logic [36:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one word, then compare {valid,result,inv,unimpl,zero,sign}
  task automatic conv(input string tag, input logic dir, input logic [1:0] rm,
                      input logic [31:0] op, input logic [31:0] er,
                      input logic ei, input logic eu);
    logic ez, es;
    @(negedge clk);
    in_valid = 1'b1; in_dir = dir; in_rmode = rm; in_operand = op;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    ez = (er == 32'h0);
    es = dir ? 1'b0 : er[31];
    check(tag, {out_valid, out_result, out_invalid, out_unimpl, out_zero, out_sign},
          {1'b1, er, ei, eu, ez, es});
  endtask

  task automatic t_reset;
    check("R1 reset idle", {36'h0, out_valid}, 37'h0);
    check("R1 reset ready", {36'h0, in_ready}, 37'h1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {35'h0, out_valid, in_ready}, 37'h1);
  endtask

  task automatic t_f2u_basic;
    conv("R2 +0", 0, 2'b00, 32'h0000_0000, 32'h0, 0, 0);
    conv("R2 -0", 0, 2'b00, 32'h8000_0000, 32'h0, 0, 0);
    conv("R2 1.0", 0, 2'b00, 32'h3F80_0000, 32'd1, 0, 0);
    conv("R2 1.5 truncates", 0, 2'b00, 32'h3FC0_0000, 32'd1, 0, 0);
    conv("R2 1.5 mode +inf ignored", 0, 2'b10, 32'h3FC0_0000, 32'd1, 0, 0);
    conv("R2 0.75", 0, 2'b00, 32'h3F40_0000, 32'd0, 0, 0);
    conv("R2 100.0", 0, 2'b01, 32'h42C8_0000, 32'd100, 0, 0);
    conv("R2 largest", 0, 2'b00, 32'h4F7F_FFFF, 32'hFFFF_FF00, 0, 0);
  endtask

  task automatic t_f2u_range;
    conv("R3 +inf", 0, 2'b00, 32'h7F80_0000, 32'hFFFF_FFFF, 1, 0);
    conv("R3 -inf", 0, 2'b00, 32'hFF80_0000, 32'h0, 1, 0);
    conv("R3 2^32 overflow", 0, 2'b00, 32'h4F80_0000, 32'hFFFF_FFFF, 1, 0);
    conv("R3 -1.0", 0, 2'b00, 32'hBF80_0000, 32'h0, 0, 0);
    conv("R3 -2^40", 0, 2'b00, 32'hD380_0000, 32'h0, 0, 0);
  endtask

  task automatic t_nan_denorm;
    conv("R4 +qNaN", 0, 2'b00, 32'h7FC0_0000, 32'hFFFF_FFFF, 1, 0);
    conv("R4 -qNaN", 0, 2'b00, 32'hFFC0_0000, 32'h0, 1, 0);
    conv("R4 +sNaN", 0, 2'b00, 32'h7F80_0001, 32'hFFFF_FFFF, 1, 0);
    conv("R4 -sNaN", 0, 2'b00, 32'hFF80_0001, 32'h0, 1, 0);
    conv("R5 +denormal", 0, 2'b00, 32'h0000_0001, 32'h0, 0, 1);
    conv("R5 -denormal", 0, 2'b00, 32'h8040_0000, 32'h0, 0, 1);
  endtask

  task automatic t_u2f;
    conv("R6 zero", 1, 2'b00, 32'h0, 32'h0, 0, 0);
    conv("R6 one", 1, 2'b00, 32'd1, 32'h3F80_0000, 0, 0);
    conv("R6 2^31", 1, 2'b00, 32'h8000_0000, 32'h4F00_0000, 0, 0);
    conv("R6 100", 1, 2'b01, 32'd100, 32'h42C8_0000, 0, 0);
    conv("R7 nearest top bit", 1, 2'b00, 32'h0100_0001, 32'h4B80_0001, 0, 0);
    conv("R7 zero top bit", 1, 2'b01, 32'h0100_0001, 32'h4B80_0000, 0, 0);
    conv("R7 +inf top bit", 1, 2'b10, 32'h0100_0001, 32'h4B80_0001, 0, 0);
    conv("R7 -inf top bit", 1, 2'b11, 32'h0100_0001, 32'h4B80_0000, 0, 0);
    conv("R7 nearest low bit", 1, 2'b00, 32'h0200_0001, 32'h4C00_0000, 0, 0);
    conv("R7 +inf low bit", 1, 2'b10, 32'h0200_0001, 32'h4C00_0001, 0, 0);
    conv("R8 carry nearest", 1, 2'b00, 32'hFFFF_FFFF, 32'h4F80_0000, 0, 0);
    conv("R8 carry +inf", 1, 2'b10, 32'hFFFF_FF01, 32'h4F80_0000, 0, 0);
    conv("R8 no carry zero", 1, 2'b01, 32'hFFFF_FFFF, 32'h4F7F_FFFF, 0, 0);
    conv("R9 sign clear u2f", 1, 2'b11, 32'hFFFF_FFFF, 32'h4F7F_FFFF, 0, 0);
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_dir = 1'b0; in_rmode = 2'b00; in_operand = 32'h4120_0000;
    @(posedge clk);
    @(negedge clk);
    check("R10 first out", {out_valid, out_result, 4'b0}, {1'b1, 32'd10, 4'b0});
    check("R10 ready low in stall", {36'h0, in_ready}, 37'h0);
    in_operand = 32'h4140_0000;
    @(posedge clk);
    @(negedge clk);
    check("R10 held in stall", {out_valid, out_result, 4'b0}, {1'b1, 32'd10, 4'b0});
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 second after drain", {out_valid, out_result, 4'b0}, {1'b1, 32'd12, 4'b0});
    @(posedge clk);
    @(negedge clk);
    check("R10 empty after drain", {36'h0, out_valid}, 37'h0);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
    repeat (3) @(posedge clk);
    t_reset();
    t_f2u_basic();
    t_f2u_range();
    t_nan_denorm();
    t_u2f();
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule